// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block sits between an SPI word source and the serial shift engine and owns the chip-select lines and the timing around every word. A word request names the devices to select, whether CS must stay low after the word, and whether an inter-word pause follows. The sequencer drops the chosen active-low select lines and waits a programmable setup time. It then pulses `shift_start` to the shift engine and waits for `shift_done`. After a programmable hold time it releases CS, unless hold was requested. Last, it can idle for a programmable number of cycles before it takes the next word.

An optional handshake with the slave's ready input adds two timeout windows. The slave must raise ready within a set number of cycles after CS falls, or a timeout error is raised. It must drop ready within a second window after the word ends, or a desynchronization error is raised. Either error aborts the word, releases every select line and returns the sequencer to idle. All delays count module clock cycles. The configuration inputs are quasi-static: they are held steady while a word is in flight.

Top module: `cs_timing_seq`

## Requirements
- R1: After reset every `cs_n` line is high, `req_ready` is high, and `shift_start`, `err_timeout` and `err_desync` are low.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle each line whose `req_sel` bit is 0 and whose `pin_en` bit is 1 drives low. Lines with `pin_en` 0 stay high whatever `req_sel` holds.
- R3: `shift_start` is high for exactly one cycle, and that cycle comes `cfg_c2t` cycles after the first cycle with CS low (the same cycle when `cfg_c2t` is 0).
- R4: When `cfg_timer_dis` is 1, both the setup delay and the hold delay are treated as 0.
- R5: If `shift_done` is high in cycle d, CS is low through cycle d+1+`cfg_t2c` and goes high in cycle d+2+`cfg_t2c`.
- R6: A word accepted with `req_hold` 1 leaves CS low after it ends, with `req_ready` high. A following word with `req_hold` 0 is sequenced with no CS release between the two words.
- R7: With `req_wdel_en` 1 and `cfg_wdelay` N > 0, `req_ready` rises N cycles after CS is released. With `req_wdel_en` 0 it rises in the same cycle that CS is released.
- R8: With `cfg_wait_en` 1, `shift_start` is raised in the first setup cycle in which the setup delay has elapsed and `slv_rdy` is high.
- R9: With `cfg_wait_en` 1 and `slv_rdy` low, `err_timeout` pulses for one cycle in cycle f+`cfg_c2e`+1, where f is the first cycle with CS low. In that cycle all `cs_n` lines are high and `req_ready` is high, and no `shift_start` occurs.
- R10: With `cfg_wait_en` 1 and `slv_rdy` still high after the word, `err_desync` pulses for one cycle in cycle d+`cfg_t2e`+2, where d is the cycle with `shift_done` high. CS goes high in that same cycle.
- R11: A `req_valid` raised while `req_ready` is low is ignored. CS and the word in flight are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_en | input | NUM_CS | 1 = line acts as a chip select |
| cfg_c2t | input | DLY_W | CS-fall to shift-start setup cycles |
| cfg_t2c | input | DLY_W | Word-end to CS-release hold cycles |
| cfg_t2e | input | DLY_W | Window for ready release after the word |
| cfg_c2e | input | DLY_W | Window for ready assertion after CS falls |
| cfg_wdelay | input | WDLY_W | Idle cycles inserted between words |
| cfg_timer_dis | input | 1 | Bypass setup and hold delays |
| cfg_wait_en | input | 1 | Enable the slave ready handshake |
| req_valid | input | 1 | Word request |
| req_sel | input | NUM_CS | Select pattern, a 0 bit selects the line |
| req_hold | input | 1 | Keep CS low after this word |
| req_wdel_en | input | 1 | Insert the inter-word pause after this word |
| req_ready | output | 1 | Sequencer can accept a word |
| shift_start | output | 1 | One-cycle start pulse to the shift engine |
| shift_done | input | 1 | Shift engine finished the word |
| slv_rdy | input | 1 | Slave ready, active high |
| cs_n | output | NUM_CS | Active-low chip selects |
| err_timeout | output | 1 | Ready was not seen in the setup window |
| err_desync | output | 1 | Ready was not released after the word |

## Verification
The bench builds the block with its defaults: eight select lines, 8-bit delays and a 6-bit word pause. With these values a setup delay of 255 and a word pause of 63, the top of each field, can be run within the cycle budget. The bench also checks pin masking over all eight lines and both error aborts with small windows, so every edge of the timing can be counted against the requirement formulas.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TAIL  = 3'd3,
    ST_GAP   = 3'd4,
    ST_HELD  = 3'd5
  } seq_state_t;

  localparam int CMP_W = 16;

  // count has reached a programmed limit (limit 0 is reached at once)
  function automatic logic reached(input logic [CMP_W-1:0] cnt,
                                   input logic [CMP_W-1:0] lim);
    return cnt >= lim;
  endfunction

  // last cycle of a pause that lasts len cycles, counted from 0
  function automatic logic gap_over(input logic [CMP_W-1:0] cnt,
                                    input logic [CMP_W-1:0] len);
    return (cnt + 1'b1) >= len;
  endfunction

endpackage

// File: rtl/cs_delay_cnt.sv
module cs_delay_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (q != '1)    q <= q + 1'b1;
  end

  // R3: the delay counter advances by one each cycle until it saturates
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && q != '1) |=> q == W'($past(q) + 1'b1));

endmodule

// File: rtl/cs_ready_mon.sv
module cs_ready_mon
  import cs_seq_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_setup,
  input  logic             in_tail,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DLY_W-1:0] c2t,
  input  logic [DLY_W-1:0] t2c,
  input  logic [DLY_W-1:0] t2e,
  input  logic [DLY_W-1:0] c2e,
  input  logic             timer_dis,
  input  logic             wait_en,
  input  logic             rdy,
  output logic             setup_go,
  output logic             setup_tmo,
  output logic             tail_go,
  output logic             tail_dsy
);

  logic c2t_ok, t2c_ok;

  always_comb begin
    c2t_ok    = timer_dis || reached(CMP_W'(cnt), CMP_W'(c2t));
    t2c_ok    = timer_dis || reached(CMP_W'(cnt), CMP_W'(t2c));
    setup_go  = in_setup && c2t_ok && (!wait_en || rdy);
    setup_tmo = in_setup && wait_en && !rdy && reached(CMP_W'(cnt), CMP_W'(c2e));
    tail_go   = in_tail && t2c_ok && (!wait_en || !rdy);
    tail_dsy  = in_tail && wait_en && rdy && reached(CMP_W'(cnt), CMP_W'(t2e));
  end

  // R8: with the handshake on, the word never starts without ready
  p_go_needs_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_go && wait_en) |-> rdy);

  // R10: with the handshake on, the tail only ends once ready is released
  p_tail_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_go && wait_en) |-> !rdy);

  // R9: a timeout and a start never coincide
  p_tmo_or_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_go && setup_tmo));

endmodule

// File: rtl/cs_line_drv.sv
module cs_line_drv #(
  parameter int NUM_CS = 8
) (
  input  logic              cs_act,
  input  logic [NUM_CS-1:0] sel,
  input  logic [NUM_CS-1:0] pin_en,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = !(cs_act && pin_en[i] && !sel[i]);
  end

endmodule

// File: rtl/cs_timing_seq.sv
module cs_timing_seq
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DLY_W  = 8,
  parameter int WDLY_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] pin_en,
  input  logic [DLY_W-1:0]  cfg_c2t,
  input  logic [DLY_W-1:0]  cfg_t2c,
  input  logic [DLY_W-1:0]  cfg_t2e,
  input  logic [DLY_W-1:0]  cfg_c2e,
  input  logic [WDLY_W-1:0] cfg_wdelay,
  input  logic              cfg_timer_dis,
  input  logic              cfg_wait_en,
  input  logic              req_valid,
  input  logic [NUM_CS-1:0] req_sel,
  input  logic              req_hold,
  input  logic              req_wdel_en,
  output logic              req_ready,
  output logic              shift_start,
  input  logic              shift_done,
  input  logic              slv_rdy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              err_timeout,
  output logic              err_desync
);

  localparam int CNT_W = ((DLY_W > WDLY_W) ? DLY_W : WDLY_W) + 1;

  seq_state_t        state_q, state_d;
  logic [NUM_CS-1:0] sel_q;
  logic              hold_q, wdel_q;
  logic              tmo_q, dsy_q;
  logic              accept, tmo_d, dsy_d;
  logic              cnt_clr, cs_act;
  logic [CNT_W-1:0]  cnt_q;
  logic              setup_go, setup_tmo, tail_go, tail_dsy;
  logic              gap_wanted;

  cs_delay_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .q     (cnt_q)
  );

  cs_ready_mon #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_setup  (state_q == ST_SETUP),
    .in_tail   (state_q == ST_TAIL),
    .cnt       (cnt_q),
    .c2t       (cfg_c2t),
    .t2c       (cfg_t2c),
    .t2e       (cfg_t2e),
    .c2e       (cfg_c2e),
    .timer_dis (cfg_timer_dis),
    .wait_en   (cfg_wait_en),
    .rdy       (slv_rdy),
    .setup_go  (setup_go),
    .setup_tmo (setup_tmo),
    .tail_go   (tail_go),
    .tail_dsy  (tail_dsy)
  );

  cs_line_drv #(.NUM_CS(NUM_CS)) u_drv (
    .cs_act (cs_act),
    .sel    (sel_q),
    .pin_en (pin_en),
    .cs_n   (cs_n)
  );

  assign gap_wanted = wdel_q && (cfg_wdelay != '0);

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    tmo_d   = 1'b0;
    dsy_d   = 1'b0;
    case (state_q)
      ST_IDLE, ST_HELD: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (setup_go) begin
          state_d = ST_SHIFT;
        end else if (setup_tmo) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (shift_done) state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (tail_go) begin
          if (gap_wanted)  state_d = ST_GAP;
          else if (hold_q) state_d = ST_HELD;
          else             state_d = ST_IDLE;
        end else if (tail_dsy) begin
          state_d = ST_IDLE;
          dsy_d   = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_over(CMP_W'(cnt_q), CMP_W'(cfg_wdelay)))
          state_d = hold_q ? ST_HELD : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr     = (state_d != state_q);
  assign req_ready   = (state_q == ST_IDLE) || (state_q == ST_HELD);
  assign shift_start = setup_go;
  assign cs_act      = (state_q == ST_SETUP) || (state_q == ST_SHIFT) ||
                       (state_q == ST_TAIL)  ||
                       (((state_q == ST_GAP) || (state_q == ST_HELD)) && hold_q);
  assign err_timeout = tmo_q;
  assign err_desync  = dsy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '1;
      hold_q  <= 1'b0;
      wdel_q  <= 1'b0;
      tmo_q   <= 1'b0;
      dsy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      dsy_q   <= dsy_d;
      if (accept) begin
        sel_q  <= req_sel;
        hold_q <= req_hold;
        wdel_q <= req_wdel_en;
      end
    end
  end

  // R1: idle means every select line is released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (cs_n == '1));

  // R3: a start pulse hands the word to the shift engine
  p_start_to_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_start |=> (state_q == ST_SHIFT));

  // R5: the sequencer stays with the word until the engine reports done
  p_wait_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && !shift_done) |=> (state_q == ST_SHIFT));

  // R6: the held state is only reached for a word that asked for hold
  p_held_has_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD) |-> hold_q);

  // R9: a timeout releases all lines and reopens the request side
  p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (cs_n == '1 && req_ready));

  // R10: a desync releases all lines
  p_dsy_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_desync |-> (cs_n == '1));

  // R9, R10: the two error flags never fire together
  p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_timeout, err_desync}));

  // R11: a request during a word does not disturb the latched selection
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && req_valid) |=> $stable(sel_q));

endmodule

// File: tb/sim_cs_timing_seq.sv
module sim_cs_timing_seq;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_en = '1;
  logic [7:0]   cfg_c2t = '0, cfg_t2c = '0, cfg_t2e = '0, cfg_c2e = '0;
  logic [5:0]   cfg_wdelay = '0;
  logic         cfg_timer_dis = 1'b0, cfg_wait_en = 1'b0;
  logic         req_valid = 1'b0;
  logic [N-1:0] req_sel = '1;
  logic         req_hold = 1'b0, req_wdel_en = 1'b0;
  logic         req_ready, shift_start;
  logic         shift_done = 1'b0;
  logic         slv_rdy = 1'b0;
  logic [N-1:0] cs_n;
  logic         err_timeout, err_desync;

  cs_timing_seq u0 (
    .clk(clk), .rst_n(rst_n), .pin_en(pin_en),
    .cfg_c2t(cfg_c2t), .cfg_t2c(cfg_t2c), .cfg_t2e(cfg_t2e), .cfg_c2e(cfg_c2e),
    .cfg_wdelay(cfg_wdelay), .cfg_timer_dis(cfg_timer_dis), .cfg_wait_en(cfg_wait_en),
    .req_valid(req_valid), .req_sel(req_sel), .req_hold(req_hold),
    .req_wdel_en(req_wdel_en), .req_ready(req_ready), .shift_start(shift_start),
    .shift_done(shift_done), .slv_rdy(slv_rdy), .cs_n(cs_n),
    .err_timeout(err_timeout), .err_desync(err_desync)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // observed events, recorded between edges
  int t_fall, t_start, t_rise, t_rr, t_tmo, t_dsy, t_done;
  int n_start, n_rise;
  logic [N-1:0] cs_at_fall, cs_at_tmo, cs_at_dsy;
  logic rr_at_tmo;
  logic [N-1:0] prev_cs = '1;
  logic prev_rr = 1'b1;
  int eng = 0;

  // shift engine model: done three cycles after the start pulse
  always begin
    @(negedge clk); #1;
    shift_done = 1'b0;
    if (shift_start) eng = 3;
    else if (eng > 0) begin
      eng--;
      if (eng == 0) begin shift_done = 1'b1; t_done = cyc; end
    end
  end

  always begin
    @(negedge clk); #2;
    if (cs_n != '1 && prev_cs == '1) begin t_fall = cyc; cs_at_fall = cs_n; end
    if (cs_n == '1 && prev_cs != '1) begin t_rise = cyc; n_rise++; end
    if (shift_start) begin t_start = cyc; n_start++; end
    if (req_ready && !prev_rr) t_rr = cyc;
    if (err_timeout) begin t_tmo = cyc; cs_at_tmo = cs_n; rr_at_tmo = req_ready; end
    if (err_desync) begin t_dsy = cyc; cs_at_dsy = cs_n; end
    prev_cs = cs_n;
    prev_rr = req_ready;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    t_fall = -1; t_start = -1; t_rise = -1; t_rr = -1;
    t_tmo = -1; t_dsy = -1; t_done = -1;
    n_start = 0; n_rise = 0;
  endtask

  task automatic set_cfg(input int c2t, input int t2c, input int t2e, input int c2e,
                         input int wd, input bit tdis, input bit wen);
    cfg_c2t = 8'(c2t); cfg_t2c = 8'(t2c); cfg_t2e = 8'(t2e); cfg_c2e = 8'(c2e);
    cfg_wdelay = 6'(wd); cfg_timer_dis = tdis; cfg_wait_en = wen;
  endtask

  // returns at the falling edge inside the first cycle after acceptance
  task automatic send(input logic [N-1:0] sel, input bit hold, input bit wdel);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_sel = sel; req_hold = hold; req_wdel_en = wdel; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n idle", int'(cs_n), 8'hFF);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 shift_start", int'(shift_start), 0);
    chk("R1 errors", int'({err_timeout, err_desync}), 0);
  endtask

  task automatic t_basic();
    clr_mon(); set_cfg(3, 2, 0, 0, 0, 0, 0);
    send(8'hFB, 0, 0); settle(20);
    chk("R2 selected pattern", int'(cs_at_fall), 8'hFB);
    chk("R3 setup delay", t_start - t_fall, 3);
    chk("R3 single start", n_start, 1);
    chk("R5 hold delay", t_rise - t_done, 4);
    chk("R7 no pause", t_rr - t_rise, 0);
  endtask

  task automatic t_pin_mask();
    clr_mon(); set_cfg(0, 0, 0, 0, 0, 0, 0); pin_en = 8'hF0;
    send(8'h00, 0, 0); settle(12);
    chk("R2 pin mask", int'(cs_at_fall), 8'h0F);
    chk("R3 zero setup", t_start - t_fall, 0);
    pin_en = 8'hFF;
  endtask

  task automatic t_long_setup();
    clr_mon(); set_cfg(255, 0, 0, 0, 0, 0, 0);
    send(8'h7F, 0, 0); settle(270);
    chk("R3 max setup", t_start - t_fall, 255);
    chk("R5 zero hold", t_rise - t_done, 2);
  endtask

  task automatic t_timer_off();
    clr_mon(); set_cfg(9, 9, 0, 0, 0, 1, 0);
    send(8'hFE, 0, 0); settle(15);
    chk("R4 setup bypass", t_start - t_fall, 0);
    chk("R4 hold bypass", t_rise - t_done, 2);
  endtask

  task automatic t_hold();
    clr_mon(); set_cfg(1, 1, 0, 0, 0, 0, 0);
    send(8'hFB, 1, 0); settle(15);
    chk("R6 cs kept low", int'(cs_n), 8'hFB);
    chk("R6 ready while held", int'(req_ready), 1);
    chk("R6 no release", n_rise, 0);
    send(8'hFB, 0, 0); settle(15);
    chk("R6 one release", n_rise, 1);
    chk("R6 two words", n_start, 2);
    chk("R6 final idle", int'(cs_n), 8'hFF);
  endtask

  task automatic t_pause(input int wd, input bit en, input int exp);
    clr_mon(); set_cfg(1, 1, 0, 0, wd, 0, 0);
    send(8'hEF, 0, en); settle(wd + 15);
    chk("R7 pause length", t_rr - t_rise, exp);
  endtask

  task automatic t_wait_ok();
    clr_mon(); set_cfg(2, 1, 10, 20, 0, 0, 1); slv_rdy = 1'b0;
    send(8'hFD, 0, 0);
    settle(5); slv_rdy = 1'b1;
    settle(3); slv_rdy = 1'b0;
    settle(10);
    chk("R8 start waits ready", t_start - t_fall, 5);
    chk("R8 hold after word", t_rise - t_done, 3);
    chk("R8 no timeout", t_tmo, -1);
    chk("R8 no desync", t_dsy, -1);
  endtask

  task automatic t_timeout();
    clr_mon(); set_cfg(1, 1, 0, 4, 0, 0, 1); slv_rdy = 1'b0;
    send(8'hBF, 0, 0); settle(12);
    chk("R9 timeout cycle", t_tmo - t_fall, 5);
    chk("R9 cs released", int'(cs_at_tmo), 8'hFF);
    chk("R9 ready back", int'(rr_at_tmo), 1);
    chk("R9 no start", n_start, 0);
  endtask

  task automatic t_desync();
    clr_mon(); set_cfg(1, 1, 3, 9, 0, 0, 1); slv_rdy = 1'b1;
    send(8'hDF, 0, 0); settle(15);
    chk("R10 desync cycle", t_dsy - t_done, 5);
    chk("R10 cs released", int'(cs_at_dsy), 8'hFF);
    chk("R10 release with flag", t_rise, t_dsy);
    slv_rdy = 1'b0;
  endtask

  task automatic t_busy();
    clr_mon(); set_cfg(2, 1, 0, 0, 0, 0, 0);
    send(8'hFB, 0, 0);
    settle(3); req_sel = 8'h00; req_valid = 1'b1;
    settle(1); req_valid = 1'b0;
    chk("R11 cs unchanged", int'(cs_n), 8'hFB);
    settle(12);
    chk("R11 single word", n_start, 1);
    chk("R11 single release", n_rise, 1);
  endtask

  initial begin
    clr_mon();
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_basic();
    t_pin_mask();
    t_long_setup();
    t_timer_off();
    t_hold();
    t_pause(5, 1, 5);
    t_pause(63, 1, 63);
    t_pause(5, 0, 0);
    t_wait_ok();
    t_timeout();
    t_desync();
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-sequence act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule